// File: doc/BRIEF.md
# Single-Vector Interrupt Entry Sequencer

This block sits beside the fetch stage of a small 8-bit core that has one interrupt vector. It keeps a latch bit and an enable bit for every interrupt source. Sources are split into a core group and a peripheral group. A peripheral-group gate and a master gate sit above the per-source enables. The block decides when the program flow is diverted. When it diverts, it discards the instruction already fetched, runs two idle instruction cycles, hands the interrupted fetch address to an external return stack and steers fetch to a fixed vector. A return strobe from the decoder pulls the saved address back and reopens the master gate in the same step.

Each instruction cycle is split into four quarter-phases by an internal 2-bit counter. Pending requests are sampled as the first quarter-phase ends. The fetch address changes only as the last quarter-phase ends. A stall input tells the block that the executing instruction needs a second cycle. In normal flow this holds the fetch address, but it never delays or stretches an interrupt entry. Events are single-clock pulses from the peripherals. Register writes use a select/data strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: A pulse on any event input sets that source's latch bit on the next clock edge, whatever the master gate, the peripheral gate and the source's own enable are set to.
- R2: Reset clears the master gate, the peripheral gate, every enable and every latch bit. It sets the fetch address to 0 and the quarter-phase to 0.
- R3: A core-group source requests an interrupt only when its latch, its enable and the master gate are all 1. A peripheral-group source also needs the peripheral gate to be 1.
- R4: Entry takes three instruction cycles. In the first, `flush_o` and `dummy_o` are high, the fetch address is held, the master gate reads 0, and `stk_push_o` pulses in quarter-phase 0 with the held address on `stk_wdata_o`. In the second, the fetch address is 0x004 and `dummy_o` is high. In the third, the fetch address is 0x005 and normal flow resumes.
- R5: While the master gate is 0, no entry starts. A latched and enabled source enters as soon as the master gate is written to 1, including right after a return.
- R6: A return strobe held during quarter-phase 3 of a normal cycle raises `stk_pop_o` in that phase. The next cycle fetches from `stk_rdata_i` with the master gate reading 1.
- R7: Requests are sampled at the end of quarter-phase 0. An event in quarter-phase 3 of cycle A gives one more normal cycle (A+1) and then the entry cycles. An event in quarter-phases 0 to 2 of cycle A is first seen one sample later, so it leads to the same entry cycle. This gives 3 to 4 cycles of latency.
- R8: With `stall_i` high at the end of a normal cycle, the fetch address is held. A stall never changes when entry starts or which cycles it uses. The address pushed is the address held at that time.
- R9: The quarter-phase counts 0, 1, 2, 3 and wraps. The fetch address changes only at the end of quarter-phase 3.
- R10: Entry never clears latch bits; only writes do. If a write and an event on the same bit fall on the same clock, the bit ends up 1.
- R11: Write selects: 0 = control (bit 0 master gate, bit 1 peripheral gate), 1 = core enables, 2 = core latches, 3 = peripheral enables, 4 = peripheral latches. Source n sits at data bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_evt_i | input | N_CORE | Core-group event pulses |
| peri_evt_i | input | N_PERI | Peripheral-group event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | WD | Write data |
| ret_i | input | 1 | Return-from-interrupt strobe |
| stall_i | input | 1 | Executing instruction needs a second cycle |
| stk_rdata_i | input | PC_W | Top-of-stack address |
| pc_o | output | PC_W | Current fetch address |
| qphase_o | output | 2 | Quarter-phase index |
| flush_o | output | 1 | Fetched instruction discarded this cycle |
| dummy_o | output | 1 | Idle entry cycle |
| stk_push_o | output | 1 | Push strobe |
| stk_pop_o | output | 1 | Pop strobe |
| stk_wdata_o | output | PC_W | Address to push |
| gie_o | output | 1 | Master gate state |
| core_flag_o | output | N_CORE | Core-group latch bits |
| peri_flag_o | output | N_PERI | Peripheral-group latch bits |

## Verification
The bench uses three core sources and four peripheral sources, so the write data is four bits wide. The fetch address is 13 bits and the vector is 0x004. With a peripheral group wider than the core group, one walk can show a peripheral bit being blocked by the peripheral gate while a core bit at the same index is not. The wide address lets a return land on 0x123, which is far from the vector. It also exposes the immediate re-entry that follows when a source is still latched after the return.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int N_CORE   = 3,
  parameter int N_PERI   = 4,
  parameter int PC_W     = 13,
  parameter int VECTOR   = 4,
  parameter int RESET_PC = 0,
  localparam int NMAX    = (N_CORE > N_PERI) ? N_CORE : N_PERI,
  localparam int WD      = (NMAX > 2) ? NMAX : 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CORE-1:0] core_evt_i,
  input  logic [N_PERI-1:0] peri_evt_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [WD-1:0]     wr_data_i,
  input  logic              ret_i,
  input  logic              stall_i,
  input  logic [PC_W-1:0]   stk_rdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [1:0]        qphase_o,
  output logic              flush_o,
  output logic              dummy_o,
  output logic              stk_push_o,
  output logic              stk_pop_o,
  output logic [PC_W-1:0]   stk_wdata_o,
  output logic              gie_o,
  output logic [N_CORE-1:0] core_flag_o,
  output logic [N_PERI-1:0] peri_flag_o
);

  localparam logic [PC_W-1:0] VEC   = PC_W'(VECTOR);
  localparam logic [PC_W-1:0] VEC_1 = PC_W'(VECTOR + 1);
  localparam logic [PC_W-1:0] RST_A = PC_W'(RESET_PC);

  typedef enum logic [1:0] {S_RUN, S_IDLE1, S_IDLE2} seq_t;

  seq_t              st;
  logic [1:0]        q;
  logic [PC_W-1:0]   pc;
  logic              gie, peie, take;
  logic [N_CORE-1:0] cen, cflag;
  logic [N_PERI-1:0] pen, pflag;

  wire q_first = (q == 2'd0);
  wire q_last  = (q == 2'd3);
  wire in_run  = (st == S_RUN);

  wire wr_ctl   = wr_en_i && (wr_sel_i == 3'd0);
  wire wr_cen   = wr_en_i && (wr_sel_i == 3'd1);
  wire wr_cflag = wr_en_i && (wr_sel_i == 3'd2);
  wire wr_pen   = wr_en_i && (wr_sel_i == 3'd3);
  wire wr_pflag = wr_en_i && (wr_sel_i == 3'd4);

  wire core_req = |(cflag & cen);
  wire peri_req = peie && |(pflag & pen);
  wire req      = gie && (core_req || peri_req);

  wire ret_go = q_last && in_run && ret_i;
  wire enter  = q_last && in_run && take && !ret_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= 2'd0;
    else        q <= q + 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 take <= 1'b0;
    else if (q_first && in_run) take <= req;
    else if (q_last)            take <= 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RUN;
      pc <= RST_A;
    end else if (q_last) begin
      unique case (st)
        S_RUN: begin
          if (ret_go)        pc <= stk_rdata_i;
          else if (take)     st <= S_IDLE1;
          else if (!stall_i) pc <= pc + PC_W'(1);
        end
        S_IDLE1: begin
          pc <= VEC;
          st <= S_IDLE2;
        end
        default: begin
          pc <= VEC_1;
          st <= S_RUN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie  <= 1'b0;
      peie <= 1'b0;
    end else begin
      if (enter)       gie <= 1'b0;
      else if (ret_go) gie <= 1'b1;
      else if (wr_ctl) gie <= wr_data_i[0];
      if (wr_ctl)      peie <= wr_data_i[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen   <= '0;
      pen   <= '0;
      cflag <= '0;
      pflag <= '0;
    end else begin
      if (wr_cen) cen <= wr_data_i[N_CORE-1:0];
      if (wr_pen) pen <= wr_data_i[N_PERI-1:0];
      cflag <= (wr_cflag ? wr_data_i[N_CORE-1:0] : cflag) | core_evt_i;
      pflag <= (wr_pflag ? wr_data_i[N_PERI-1:0] : pflag) | peri_evt_i;
    end
  end

  assign pc_o        = pc;
  assign qphase_o    = q;
  assign flush_o     = (st == S_IDLE1);
  assign dummy_o     = !in_run;
  assign stk_push_o  = (st == S_IDLE1) && q_first;
  assign stk_wdata_o = pc;
  assign stk_pop_o   = ret_go;
  assign gie_o       = gie;
  assign core_flag_o = cflag;
  assign peri_flag_o = pflag;

  AST_CORE_FLAG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (core_evt_i != '0) |=> ((core_flag_o & $past(core_evt_i)) == $past(core_evt_i))); // R1
  AST_PERI_FLAG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (peri_evt_i != '0) |=> ((peri_flag_o & $past(peri_evt_i)) == $past(peri_evt_i))); // R1
  AST_ENTRY_CLOSES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_o) |-> !gie_o); // R4
  AST_VECTOR_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy_o && !flush_o) |-> (pc_o == VEC)); // R4
  AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push_o |=> !stk_push_o); // R4
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_first && in_run && !gie) |=> !take); // R5
  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    stk_pop_o |=> (gie_o && (pc_o == $past(stk_rdata_i)))); // R6
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (qphase_o == 2'($past(qphase_o) + 2'd1))); // R9
  AST_PC_MIDCYCLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (qphase_o != 2'd3) |=> $stable(pc_o)); // R9

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam int NC = 3, NP = 4, PW = 13, WD = 4;
  localparam int VEC = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] core_evt = '0;
  logic [NP-1:0] peri_evt = '0;
  logic          wr_en = 1'b0, ret = 1'b0, stall = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [WD-1:0] wr_data = '0;
  logic [PW-1:0] stk_rdata = '0;
  logic [PW-1:0] pc, stk_wdata;
  logic [1:0]    qph;
  logic          flush, dummy, push, pop, gie;
  logic [NC-1:0] cflag;
  logic [NP-1:0] pflag;

  int checks = 0, fails = 0;
  int a;

  irq_entry_seq #(.N_CORE(NC), .N_PERI(NP), .PC_W(PW), .VECTOR(VEC), .RESET_PC(0)) dut (
    .clk(clk), .rst_n(rst_n), .core_evt_i(core_evt), .peri_evt_i(peri_evt),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .ret_i(ret),
    .stall_i(stall), .stk_rdata_i(stk_rdata), .pc_o(pc), .qphase_o(qph),
    .flush_o(flush), .dummy_o(dummy), .stk_push_o(push), .stk_pop_o(pop),
    .stk_wdata_o(stk_wdata), .gie_o(gie), .core_flag_o(cflag), .peri_flag_o(pflag));

  always #4 clk = ~clk;

  // fields: gate, pgate, core en, peri en, core evt, peri evt, expect entry
  localparam logic [16:0] ROWS [8] = '{
    {1'b1, 1'b0, 3'b001, 4'b0000, 3'b001, 4'b0000, 1'b1},
    {1'b1, 1'b0, 3'b001, 4'b0000, 3'b010, 4'b0000, 1'b0},
    {1'b0, 1'b1, 3'b111, 4'b1111, 3'b001, 4'b0000, 1'b0},
    {1'b1, 1'b0, 3'b000, 4'b0001, 3'b000, 4'b0001, 1'b0},
    {1'b1, 1'b1, 3'b000, 4'b0001, 3'b000, 4'b0001, 1'b1},
    {1'b1, 1'b1, 3'b000, 4'b0100, 3'b000, 4'b1000, 1'b0},
    {1'b1, 1'b1, 3'b010, 4'b0000, 3'b010, 4'b0000, 1'b1},
    {1'b1, 1'b1, 3'b000, 4'b1000, 3'b001, 4'b1000, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int k);
    do @(negedge clk); while (qph != 2'(k));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    core_evt = '0; peri_evt = '0; wr_en = 1'b0; ret = 1'b0; stall = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = WD'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int c, input int p);
    core_evt = NC'(c); peri_evt = NP'(p);
    @(negedge clk);
    core_evt = '0; peri_evt = '0;
  endtask

  task automatic check_entry(input int ret_addr);
    wait_q(1);
    chk("R7 normal cycle before entry pc", int'(pc), ret_addr);
    chk("R7 no flush before entry", int'(flush), 0);
    wait_q(0);
    chk("R4 flush in first entry cycle", int'(flush), 1);
    chk("R4 dummy in first entry cycle", int'(dummy), 1);
    chk("R4 push strobe", int'(push), 1);
    chk("R4 pushed address", int'(stk_wdata), ret_addr);
    chk("R4 gate cleared on entry", int'(gie), 0);
    wait_q(0);
    chk("R4 vector fetch", int'(pc), VEC);
    chk("R4 second cycle dummy", int'(dummy), 1);
    chk("R4 no push in second cycle", int'(push), 0);
    wait_q(0);
    chk("R4 vector plus one", int'(pc), VEC + 1);
    chk("R4 normal flow resumes", int'(dummy), 0);
  endtask

  task automatic check_none(input int base);
    for (int i = 1; i <= 3; i++) begin
      wait_q(1);
      chk("R3 no entry pc advances", int'(pc), base + i);
      chk("R3 no dummy", int'(dummy), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    for (int r = 0; r < 8; r++) begin
      do_reset();
      wr(1, int'(ROWS[r][14:12]));          // R11 core enables
      wr(3, int'(ROWS[r][11:8]));           // R11 peripheral enables
      wr(0, int'({ROWS[r][15], ROWS[r][16]}));
      wait_q(3);
      a = int'(pc);
      pulse(int'(ROWS[r][7:5]), int'(ROWS[r][4:1]));
      chk("R1 core latch", int'(cflag), int'(ROWS[r][7:5]));
      chk("R1 peripheral latch", int'(pflag), int'(ROWS[r][4:1]));
      if (ROWS[r][0]) check_entry(a + 1);
      else            check_none(a);
    end

    // R2 reset clears everything, enables stay off
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2 reset pc", int'(pc), 0);
    chk("R2 reset phase", int'(qph), 0);
    chk("R2 reset gate", int'(gie), 0);
    chk("R2 reset latches", int'({cflag, pflag}), 0);
    do_reset();
    wr(0, 3);
    wait_q(3);
    a = int'(pc);
    pulse(7, 15);
    check_none(a);

    // R8 stall holds fetch in normal flow
    do_reset();
    wait_q(3);
    a = int'(pc);
    stall = 1'b1;
    @(negedge clk);
    stall = 1'b0;
    chk("R8 stall holds pc", int'(pc), a);

    // R5 gate closed blocks, opening it vectors
    do_reset();
    wr(1, 1);
    wait_q(3);
    a = int'(pc);
    pulse(1, 0);
    check_none(a);
    chk("R5 latch held while gate closed", int'(cflag), 1);
    wait_q(3);
    a = int'(pc);
    wr(0, 1);
    check_entry(a + 1);
    chk("R10 latch survives entry", int'(cflag), 1);

    // R6 return, then immediate re-entry on the still-latched source
    wait_q(3);
    stk_rdata = 13'h0123;
    ret = 1'b1;
    #1 chk("R6 pop strobe", int'(pop), 1);
    @(negedge clk);
    ret = 1'b0;
    chk("R6 return address", int'(pc), 'h123);
    chk("R6 gate set on return", int'(gie), 1);
    check_entry('h123);

    // R10 set wins over a clearing write
    wait_q(3);
    wr_en = 1'b1; wr_sel = 3'd2; wr_data = '0; core_evt = 3'b001;
    @(negedge clk);
    wr_en = 1'b0; core_evt = '0;
    chk("R10 set wins", int'(cflag), 1);
    wr(2, 0);
    chk("R10 write clears latch", int'(cflag), 0);

    // R7 event in quarter-phase 0 joins the same entry cycle
    do_reset();
    wr(1, 4);
    wr(0, 1);
    wait_q(0);
    a = int'(pc);
    pulse(4, 0);
    wait_q(3);
    check_entry(a + 1);

    // R8 stall during entry changes neither timing nor vector
    do_reset();
    wr(3, 2);
    wr(0, 3);
    wait_q(3);
    a = int'(pc);
    stall = 1'b1;
    pulse(0, 2);
    check_entry(a);
    stall = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule